// File: doc/BRIEF.md
# Privilege-Gated Flags Write Unit

This block keeps a 16-bit processor status word. A flag-restore operation, such as popping the flags or returning from an interrupt, writes the whole word at once. The block takes that write but decides field by field what lands. The two-bit I/O privilege field changes only when the caller runs at the most privileged level, 0. The interrupt-enable bit changes only when the caller's privilege level is numerically no greater than the I/O privilege level already stored. When a field is blocked it keeps its old value. No fault is raised.

The block receives the current privilege level, the new word and a write strobe. It returns the registered word and its decoded I/O privilege, interrupt-enable and nested-task fields. For coverage it also gives a one-cycle marker whenever a write had a field blocked. The marker is informational and is not an exception.

Top module: `flagsgate_unit`

## Requirements
- R1: On a synchronous reset, active high, the flags word becomes 0x0002 and `blocked_pulse` is 0.
- R2: The I/O privilege field, bits 13:12, takes the written value only when `cur_priv` is 0. Otherwise it keeps its old value.
- R3: The interrupt-enable bit, bit 9, takes the written value only when `cur_priv` is numerically less than or equal to the I/O privilege value stored before the write. This holds even when the same write carries a different I/O privilege value.
- R4: On every write, at any privilege level, all bits other than 13:12, 9 and 1 take the written value. The result is visible on the cycle after the strobe edge.
- R5: In a cycle without a write strobe, the flags word is unchanged.
- R6: Bit 1 of the flags word reads 1 at all times after reset, whatever is written.
- R7: `blocked_pulse` is 1 for exactly the cycle after a write in which the I/O privilege field, the interrupt-enable bit, or both were blocked. The value being written does not matter. Otherwise it is 0.
- R8: `io_priv` equals bits 13:12 of the word. `int_en` equals bit 9. `nested_task` equals bit 14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cur_priv | input | 2 | Current privilege level, 0 = most privileged |
| wr_en | input | 1 | Flag-restore write strobe |
| wr_word | input | 16 | New flags word |
| flags | output | 16 | Registered flags word |
| io_priv | output | 2 | Stored I/O privilege level |
| int_en | output | 1 | Interrupt-enable bit |
| nested_task | output | 1 | Nested-task bit |
| blocked_pulse | output | 1 | A field was blocked on the previous write |

## Verification
The bench targets a write at a nonzero privilege level whose new I/O privilege value would flip the interrupt-enable decision. A design that compares against the incoming field instead of the stored one would let the bit through or wrongly block it. It also covers the equality boundary, where the privilege level equals the stored I/O level. An off-by-one comparison would block the interrupt-enable bit there. Writes that try to clear bit 1 expose a design that stores it raw. Idle cycles after a blocked write expose a marker that stays high longer than one cycle.

// File: rtl/flagsgate_pkg.sv
package flagsgate_pkg;
  typedef logic [1:0] priv_t;

  // interrupt-enable may change when the caller is at least as privileged
  function automatic logic ie_allowed(priv_t caller, priv_t stored_io);
    return caller <= stored_io;
  endfunction

  // the I/O privilege field may change only at level 0
  function automatic logic iopl_allowed(priv_t caller);
    return caller == 2'd0;
  endfunction
endpackage

// File: rtl/flagsgate_priv.sv
module flagsgate_priv
  import flagsgate_pkg::*;
(
  input  priv_t cur_priv,
  input  priv_t stored_io,
  input  logic  wr_en,
  output logic  hold_ie,
  output logic  hold_iopl,
  output logic  blocked
);
  always_comb begin
    hold_ie   = !ie_allowed(cur_priv, stored_io);
    hold_iopl = !iopl_allowed(cur_priv);
    blocked   = wr_en && (hold_ie || hold_iopl);
  end

  always_comb begin
    // level 0 may always change both fields
    if (cur_priv == 2'd0) assert_level0_free_R2: assert (!hold_ie && !hold_iopl);
  end
endmodule

// File: rtl/flagsgate_reg.sv
module flagsgate_reg #(
  parameter int unsigned W        = 16,
  parameter int unsigned IOPL_LO  = 12,
  parameter int unsigned IE_POS   = 9,
  parameter int unsigned RSVD_POS = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_word,
  input  logic         hold_ie,
  input  logic         hold_iopl,
  input  logic         blocked,
  output logic [W-1:0] flags_q,
  output logic         pulse_q
);
  localparam logic [W-1:0] IOPL_MASK = W'(3) << IOPL_LO;
  localparam logic [W-1:0] IE_MASK   = W'(1) << IE_POS;
  localparam logic [W-1:0] RSVD_MASK = W'(1) << RSVD_POS;
  localparam logic [W-1:0] FREE_MASK = ~(IOPL_MASK | IE_MASK | RSVD_MASK);
  localparam logic [W-1:0] RESET_VAL = RSVD_MASK;

  logic [W-1:0] keep_mask;
  logic [W-1:0] next_word;

  always_comb begin
    keep_mask = '0;
    if (hold_iopl) keep_mask = keep_mask | IOPL_MASK;
    if (hold_ie)   keep_mask = keep_mask | IE_MASK;
    next_word = (wr_word & ~keep_mask) | (flags_q & keep_mask) | RSVD_MASK;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= RESET_VAL;
      pulse_q <= 1'b0;
    end else begin
      if (wr_en) flags_q <= next_word;
      pulse_q <= blocked;
    end
  end

  assert_reset_value_R1: assert property (@(posedge clk)
    $past(rst) |-> (flags_q == RESET_VAL && !pulse_q));
  assert_free_bits_R4: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> ((flags_q & FREE_MASK) == ($past(wr_word) & FREE_MASK)));
  assert_idle_stable_R5: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(flags_q));
  assert_rsvd_set_R6: assert property (@(posedge clk) disable iff (rst)
    flags_q[RSVD_POS]);
  assert_pulse_after_write_R7: assert property (@(posedge clk) disable iff (rst)
    pulse_q |-> $past(wr_en));
endmodule

// File: rtl/flagsgate_unit.sv
module flagsgate_unit
  import flagsgate_pkg::*;
#(
  parameter int unsigned W        = 16,
  parameter int unsigned IOPL_LO  = 12,
  parameter int unsigned IE_POS   = 9,
  parameter int unsigned NT_POS   = 14,
  parameter int unsigned RSVD_POS = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [1:0]   cur_priv,
  input  logic         wr_en,
  input  logic [W-1:0] wr_word,
  output logic [W-1:0] flags,
  output logic [1:0]   io_priv,
  output logic         int_en,
  output logic         nested_task,
  output logic         blocked_pulse
);
  logic hold_ie, hold_iopl, blocked;

  flagsgate_priv u_priv (
    .cur_priv (cur_priv),
    .stored_io(io_priv),
    .wr_en    (wr_en),
    .hold_ie  (hold_ie),
    .hold_iopl(hold_iopl),
    .blocked  (blocked)
  );

  flagsgate_reg #(
    .W(W), .IOPL_LO(IOPL_LO), .IE_POS(IE_POS), .RSVD_POS(RSVD_POS)
  ) u_reg (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_word  (wr_word),
    .hold_ie  (hold_ie),
    .hold_iopl(hold_iopl),
    .blocked  (blocked),
    .flags_q  (flags),
    .pulse_q  (blocked_pulse)
  );

  assign io_priv     = flags[IOPL_LO+1:IOPL_LO];
  assign int_en      = flags[IE_POS];
  assign nested_task = flags[NT_POS];

  assert_iopl_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && cur_priv != 2'd0) |=> io_priv == $past(io_priv));
  assert_ie_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && cur_priv > io_priv) |=> int_en == $past(int_en));
  assert_ie_pass_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && cur_priv <= io_priv) |=> int_en == $past(wr_word[IE_POS]));
  assert_pulse_blocked_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && cur_priv != 2'd0) |=> blocked_pulse);
  assert_pulse_clear_R7: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> !blocked_pulse);
endmodule

// File: tb/test_flagsgate_unit.sv
module test_flagsgate_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  cur_priv = 2'd0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_word = '0;
  logic [15:0] flags;
  logic [1:0]  io_priv;
  logic        int_en, nested_task, blocked_pulse;

  int tests = 0;
  int fails = 0;
  logic [15:0] model = 16'h0002;
  logic        model_pulse = 1'b0;
  int unsigned seed = 32'd20240611;

  always #2 clk = ~clk;

  flagsgate_unit i_flagsgate_unit (
    .clk(clk), .rst(rst), .cur_priv(cur_priv), .wr_en(wr_en), .wr_word(wr_word),
    .flags(flags), .io_priv(io_priv), .int_en(int_en),
    .nested_task(nested_task), .blocked_pulse(blocked_pulse)
  );

  function automatic logic [15:0] restore(logic [15:0] old, logic [1:0] lvl,
                                          logic [15:0] data);
    logic [15:0] r;
    r = data | 16'h0002;
    if (lvl != 2'd0) r[13:12] = old[13:12];
    if (lvl > old[13:12]) r[9] = old[9];
    return r;
  endfunction

  function automatic logic was_blocked(logic [15:0] old, logic [1:0] lvl);
    return (lvl != 2'd0) || (lvl > old[13:12]);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_all();
    check("R2 iopl field", 32'(flags[13:12]), 32'(model[13:12]));
    check("R3 ie bit", 32'(flags[9]), 32'(model[9]));
    check("R4 free bits", 32'(flags & 16'hCDFD), 32'(model & 16'hCDFD));
    check("R6 bit1", 32'(flags[1]), 32'd1);
    check("R7 pulse", 32'(blocked_pulse), 32'(model_pulse));
    check("R8 decode", {io_priv, int_en, nested_task},
          {model[13:12], model[9], model[14]});
  endtask

  // drive at negedge, sample one period later at the next negedge
  task automatic do_write(logic [1:0] lvl, logic [15:0] data);
    cur_priv = lvl; wr_word = data; wr_en = 1'b1;
    model_pulse = was_blocked(model, lvl);
    model = restore(model, lvl, data);
    @(negedge clk);
    wr_en = 1'b0;
    check_all();
  endtask

  task automatic do_idle(logic [1:0] lvl, logic [15:0] data);
    cur_priv = lvl; wr_word = data; wr_en = 1'b0;
    model_pulse = 1'b0;
    @(negedge clk);
    check("R5 idle hold", 32'(flags), 32'(model));
    check("R7 pulse low", 32'(blocked_pulse), 32'd0);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(seed));
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    check("R1 reset word", 32'(flags), 32'h0002);
    check("R1 reset pulse", 32'(blocked_pulse), 32'd0);
    do_write(2'd0, 16'h7200);   // level 0: iopl=3, ie=1, nt=1
    do_write(2'd3, 16'h0000);   // equality boundary: ie clears, iopl held
    do_write(2'd0, 16'h1000);   // iopl=1
    do_write(2'd2, 16'h3200);   // ie and iopl both held
    do_write(2'd0, 16'h3000);   // iopl=3
    do_write(2'd2, 16'h0200);   // old iopl 3 allows ie despite new iopl 0 (R3)
    do_write(2'd1, 16'h0000);   // try to clear bit 1 (R6)
    do_idle(2'd0, 16'hFFFF);    // R5 with inputs toggled
    for (int i = 0; i < 400; i++) begin
      if ($urandom % 4 == 0) do_idle(2'($urandom), 16'($urandom));
      else do_write(2'($urandom), 16'($urandom));
    end
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    model = 16'h0002; model_pulse = 1'b0;
    check("R1 re-reset word", 32'(flags), 32'h0002);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule